// File: doc/BRIEF.md
# PCI sideband signal control register

This block is one control and status word for a PCI bridge controller. While power-on reset is held, it follows two configuration strap pins. When power-on reset is released it freezes them and reports them as read-only monitor bits. One bit reports whether host arbitration is disabled. The other reports whether the feedback clock is chosen as the PCI clock. The block does not act on these values. It only reports them.

Software also uses the word to drive three open-drain PCI sideband pins: the system-error line, interrupt line A and the PCI bus reset. Each pin appears at the block edge as an active-high output enable. An enable of 1 means the pin is pulled low. Nothing here ever drives a pin high.

- A system-error request is a one-clock pulse that fires only when the external enable allows it. In host mode the pulse goes to the local processor as an interrupt and does not appear on the pin.
- The interrupt line is driven only outside host mode.
- The bus-reset bit survives soft reset and is ORed with power-on reset.

Top module: `pci_sb_ctrl`

## Requirements
- R1: While `por` is 1, `rst_oe` is 1 and `serr_oe`, `serr_irq`, `inta_oe` and `rsp_rdata` are 0. After `por` falls, bits 3..1 of the word read back as 0.
- R2: Word bits 5 and 4 read back the values that `strap_in[1]` and `strap_in[0]` had at the last rising clock edge with `por` at 1. Later changes on `strap_in` do not alter them until the next power-on reset.
- R3: Writes cannot change bits 5 and 4. Bits 0 and 6 and above always read as 0.
- R4: Outside host mode, a write of 1 to bit 3 while `serr_en` is 1 makes `serr_oe` 1 for exactly the clock after the write edge. Bit 3 always reads back as 0.
- R5: A write of 1 to bit 3 while `serr_en` is 0 produces neither `serr_oe` nor `serr_irq`.
- R6: In host mode, the same write makes `serr_irq` 1 for exactly the clock after the write edge, and `serr_oe` stays 0.
- R7: Bit 2 is read/write. `inta_oe` equals bit 2 AND NOT `host_mode`.
- R8: Bit 1 is read/write. `rst_oe` equals bit 1 OR `por`. Only `por` clears bit 1, and `srst` leaves it unchanged.
- R9: A clock edge with `srst` at 1 clears bit 2 and suppresses a bit-3 pulse written at the same edge. The straps and bit 1 are kept.
- R10: The word sits at address `REG_ADDR` (default 0). A read there returns the word on `rsp_rdata` in the clock after the request edge. At other times `rsp_rdata` is 0. Reads and writes at any other address return 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| srst | input | 1 | Soft reset, synchronous, active high |
| host_mode | input | 1 | 1 when the bridge is the PCI host |
| serr_en | input | 1 | External system-error enable |
| strap_in | input | 2 | [1] arbitration-disable strap, [0] feedback-clock strap |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W (4) | Word address |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_rdata | output | DATA_W (32) | Read data, one clock after the request |
| serr_oe | output | 1 | Pull system-error line low |
| inta_oe | output | 1 | Pull interrupt line A low |
| rst_oe | output | 1 | Pull PCI bus reset low |
| serr_irq | output | 1 | One-clock system-error interrupt to the local processor |

## Verification
**System-error request.** A bit-3 write is tried under all eight combinations of host mode, enable and written value. This separates the pin pulse, the interrupt pulse and the suppressed case, and the clock after each pulse confirms it lasts one cycle.

**Straps.** All four strap patterns are loaded through power-on reset, and the pins are then inverted. This shows the captured values are frozen.

**Interrupt line.** Each combination of bit 2 and host mode is tried.

**Address decode.** Writes of all ones to every other address show that the decode ignores them.

**Resets.** Soft reset is applied with bit 1 and bit 2 both set. This distinguishes which bits survive it from which bits only power-on reset clears.

// File: rtl/pci_sb_pkg.sv
package pci_sb_pkg;
    // Bit positions inside the control word; software decodes these.
    localparam int BIT_RST    = 1;
    localparam int BIT_INTA   = 2;
    localparam int BIT_SERR   = 3;
    localparam int STRAP_LSB  = 4;
    localparam int STRAP_W    = 2;
    localparam int USED_MSB   = STRAP_LSB + STRAP_W - 1;

    // Decoded access, produced once at the top and shared by sub-blocks.
    typedef struct packed {
        logic wr_hit;
        logic rd_hit;
        logic serr_set;
        logic inta_val;
        logic rst_val;
    } sb_cmd_t;
endpackage

// File: rtl/sb_strap_capture.sv
module sb_strap_capture #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         por,
    input  logic [W-1:0] pins,
    output logic [W-1:0] straps
);
    typedef struct packed {
        logic [W-1:0] val;
    } strap_t;

    strap_t s_d, s_q;

    // Track the pins during power-on reset, hold afterwards.
    always_comb begin
        s_d = s_q;
        if (por) begin
            s_d.val = pins;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign straps = s_q.val;
endmodule

// File: rtl/sb_pulse_gen.sv
module sb_pulse_gen (
    input  logic clk,
    input  logic por,
    input  logic srst,
    input  logic serr_set,
    input  logic serr_en,
    input  logic host_mode,
    output logic serr_oe,
    output logic serr_irq
);
    typedef struct packed {
        logic oe;
        logic irq;
    } pulse_t;

    pulse_t p_d, p_q;

    // Each qualifying write yields exactly one registered pulse.
    always_comb begin
        p_d     = '0;
        if (!por && !srst && serr_set && serr_en) begin
            if (host_mode) begin
                p_d.irq = 1'b1;
            end else begin
                p_d.oe  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        p_q <= p_d;
    end

    assign serr_oe  = p_q.oe;
    assign serr_irq = p_q.irq;
endmodule

// File: rtl/sb_ctrl_bits.sv
module sb_ctrl_bits (
    input  logic clk,
    input  logic por,
    input  logic srst,
    input  logic wr_hit,
    input  logic inta_wr,
    input  logic rst_wr,
    input  logic host_mode,
    output logic inta_bit,
    output logic rst_bit,
    output logic inta_oe,
    output logic rst_oe
);
    typedef struct packed {
        logic inta;
        logic rst;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr_hit) begin
            c_d.inta = inta_wr;
            c_d.rst  = rst_wr;
        end
        // Soft reset reaches only the interrupt bit.
        if (srst) begin
            c_d.inta = 1'b0;
        end
        if (por) begin
            c_d.inta = 1'b0;
            c_d.rst  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign inta_bit = c_q.inta;
    assign rst_bit  = c_q.rst;
    assign inta_oe  = c_q.inta & ~host_mode;
    assign rst_oe   = c_q.rst | por;
endmodule

// File: rtl/sb_readback.sv
module sb_readback
    import pci_sb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               por,
    input  logic               srst,
    input  logic               rd_hit,
    input  logic [STRAP_W-1:0] straps,
    input  logic               inta_bit,
    input  logic               rst_bit,
    output logic [DATA_W-1:0]  rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t r_d, r_q;

    // Bit 3 and every unlisted bit stay 0.
    always_comb begin
        r_d = '0;
        if (rd_hit && !por && !srst) begin
            r_d.data[STRAP_LSB +: STRAP_W] = straps;
            r_d.data[BIT_INTA]             = inta_bit;
            r_d.data[BIT_RST]              = rst_bit;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign rdata = r_q.data;
endmodule

// File: rtl/pci_sb_ctrl.sv
module pci_sb_ctrl
    import pci_sb_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int REG_ADDR = 0
) (
    input  logic              clk,
    input  logic              por,
    input  logic              srst,
    input  logic              host_mode,
    input  logic              serr_en,
    input  logic [1:0]        strap_in,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              serr_oe,
    output logic              inta_oe,
    output logic              rst_oe,
    output logic              serr_irq
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    sb_cmd_t            cmd;
    logic [STRAP_W-1:0] straps;
    logic               inta_bit;
    logic               rst_bit;
    logic               unused_wdata;

    always_comb begin
        cmd          = '0;
        cmd.wr_hit   = req_valid && req_write  && (req_addr == MY_ADDR);
        cmd.rd_hit   = req_valid && !req_write && (req_addr == MY_ADDR);
        cmd.serr_set = cmd.wr_hit && req_wdata[BIT_SERR];
        cmd.inta_val = req_wdata[BIT_INTA];
        cmd.rst_val  = req_wdata[BIT_RST];
    end

    assign unused_wdata = ^req_wdata;

    sb_strap_capture #(.W(STRAP_W)) u_strap (
        .clk    (clk),
        .por    (por),
        .pins   (strap_in),
        .straps (straps)
    );

    sb_pulse_gen u_pulse (
        .clk       (clk),
        .por       (por),
        .srst      (srst),
        .serr_set  (cmd.serr_set),
        .serr_en   (serr_en),
        .host_mode (host_mode),
        .serr_oe   (serr_oe),
        .serr_irq  (serr_irq)
    );

    sb_ctrl_bits u_ctrl (
        .clk       (clk),
        .por       (por),
        .srst      (srst),
        .wr_hit    (cmd.wr_hit),
        .inta_wr   (cmd.inta_val),
        .rst_wr    (cmd.rst_val),
        .host_mode (host_mode),
        .inta_bit  (inta_bit),
        .rst_bit   (rst_bit),
        .inta_oe   (inta_oe),
        .rst_oe    (rst_oe)
    );

    sb_readback #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .por      (por),
        .srst     (srst),
        .rd_hit   (cmd.rd_hit),
        .straps   (straps),
        .inta_bit (inta_bit),
        .rst_bit  (rst_bit),
        .rdata    (rsp_rdata)
    );
endmodule

// File: rtl/pci_sb_ctrl_chk.sv
module pci_sb_ctrl_chk #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int REG_ADDR = 0
) (
    input logic              clk,
    input logic              por,
    input logic              srst,
    input logic              host_mode,
    input logic              serr_en,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              serr_oe,
    input logic              serr_irq,
    input logic              inta_oe,
    input logic              rst_oe
);
    logic wr_here;
    assign wr_here = req_valid && req_write && (req_addr == ADDR_W'(REG_ADDR));

    a_r4_serr_cause: assert property (@(posedge clk) disable iff (por)
        serr_oe |-> $past(wr_here && req_wdata[3] && serr_en && !host_mode && !srst));

    a_r5_needs_enable: assert property (@(posedge clk) disable iff (por)
        (serr_oe || serr_irq) |-> $past(serr_en));

    a_r6_irq_cause: assert property (@(posedge clk) disable iff (por)
        serr_irq |-> $past(wr_here && req_wdata[3] && serr_en && host_mode && !srst));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (por)
        !(serr_oe && serr_irq));

    a_r7_inta_rise: assert property (@(posedge clk) disable iff (por)
        ($rose(inta_oe) && $stable(host_mode)) |-> $past(wr_here && req_wdata[2]));

    a_r8_por_drives_reset: assert property (@(posedge clk)
        por |-> rst_oe);

    a_r8_reset_rise: assert property (@(posedge clk) disable iff (por)
        $rose(rst_oe) |-> $past(wr_here && req_wdata[1]));

    a_r9_soft_clear: assert property (@(posedge clk) disable iff (por)
        $past(srst) |-> (!serr_oe && !serr_irq && !inta_oe));
endmodule

bind pci_sb_ctrl pci_sb_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk       (clk),
    .por       (por),
    .srst      (srst),
    .host_mode (host_mode),
    .serr_en   (serr_en),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .serr_oe   (serr_oe),
    .serr_irq  (serr_irq),
    .inta_oe   (inta_oe),
    .rst_oe    (rst_oe)
);

// File: tb/pci_sb_ctrl_tb.sv
module pci_sb_ctrl_tb;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int RA = 0;

    logic          clk = 1'b0;
    logic          por = 1'b1;
    logic          srst = 1'b0;
    logic          host_mode = 1'b0;
    logic          serr_en = 1'b0;
    logic [1:0]    strap_in = 2'b00;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic          serr_oe, inta_oe, rst_oe, serr_irq;

    int checks = 0;
    int errors = 0;
    logic [1:0]  cs;
    logic [31:0] rd;

    always #5 clk = ~clk;

    pci_sb_ctrl #(.ADDR_W(AW), .DATA_W(DW), .REG_ADDR(RA)) u_dut (
        .clk(clk), .por(por), .srst(srst), .host_mode(host_mode),
        .serr_en(serr_en), .strap_in(strap_in), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .serr_oe(serr_oe), .inta_oe(inta_oe),
        .rst_oe(rst_oe), .serr_irq(serr_irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge; results are visible at the next falling edge.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rdw(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic do_por(input logic [1:0] s);
        @(negedge clk);
        por = 1'b1; strap_in = s;
        @(negedge clk);
        chk("R1 rst_oe during por", {31'b0, rst_oe}, 32'd1);
        chk("R1 outputs during por", {28'b0, serr_oe, serr_irq, inta_oe, 1'b0}, 32'd0);
        chk("R1 rdata during por", rsp_rdata, 32'd0);
        @(negedge clk);
        por = 1'b0;
        strap_in = ~s;
        cs = s;
    endtask

    function automatic logic [31:0] word(input logic [1:0] s, input logic i, input logic r);
        return {26'b0, s, 1'b0, i, r, 1'b0};
    endfunction

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL R1 watchdog: actual=timeout expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1, R2: every strap pattern, pins flipped after capture.
        for (int s = 0; s < 4; s++) begin
            do_por(2'(s));
            @(negedge clk);
            chk("R1 rst_oe after por", {31'b0, rst_oe}, 32'd0);
            rdw(AW'(RA), rd);
            chk("R2 strap capture", rd, word(cs, 1'b0, 1'b0));
            strap_in = 2'(s + 1);
            rdw(AW'(RA), rd);
            chk("R2 strap held", rd, word(cs, 1'b0, 1'b0));
        end

        // R4, R5, R6: sweep host mode, enable and written bit 3.
        for (int h = 0; h < 2; h++) begin
            for (int e = 0; e < 2; e++) begin
                for (int b = 0; b < 2; b++) begin
                    host_mode = h[0]; serr_en = e[0];
                    wr(AW'(RA), 32'(b) << 3);
                    chk("R4 serr_oe pulse", {31'b0, serr_oe}, {31'b0, b[0] & e[0] & ~h[0]});
                    chk("R6 serr_irq pulse", {31'b0, serr_irq}, {31'b0, b[0] & e[0] & h[0]});
                    @(negedge clk);
                    chk("R5 pulse one clock", {30'b0, serr_oe, serr_irq}, 32'd0);
                    rdw(AW'(RA), rd);
                    chk("R4 bit3 reads 0", rd, word(cs, 1'b0, 1'b0));
                end
            end
        end

        // R7: interrupt line against host mode.
        for (int h = 0; h < 2; h++) begin
            for (int b = 0; b < 2; b++) begin
                host_mode = h[0];
                wr(AW'(RA), 32'(b) << 2);
                chk("R7 inta_oe", {31'b0, inta_oe}, {31'b0, b[0] & ~h[0]});
                rdw(AW'(RA), rd);
                chk("R7 bit2 readback", rd, word(cs, b[0], 1'b0));
            end
        end
        host_mode = 1'b0;

        // R3: all ones except bit 3; straps unchanged, unused bits 0.
        wr(AW'(RA), 32'hFFFF_FFF7);
        chk("R8 rst_oe set", {31'b0, rst_oe}, 32'd1);
        rdw(AW'(RA), rd);
        chk("R3 read-only and unused bits", rd, word(cs, 1'b1, 1'b1));

        // R9: soft reset with bits 2 and 1 set, and a bit-3 write at the same edge.
        serr_en = 1'b1;
        @(negedge clk);
        srst = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(RA); req_wdata = 32'h0000_000E;
        @(negedge clk);
        srst = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        chk("R9 serr suppressed", {31'b0, serr_oe}, 32'd0);
        chk("R9 inta cleared", {31'b0, inta_oe}, 32'd0);
        chk("R8 rst kept by srst", {31'b0, rst_oe}, 32'd1);
        rdw(AW'(RA), rd);
        chk("R9 readback after srst", rd, word(cs, 1'b0, 1'b1));

        // R10: other addresses are ignored and read 0.
        wr(AW'(RA), 32'h0);
        for (int a = 0; a < (1 << AW); a++) begin
            if (a != RA) begin
                wr(AW'(a), 32'hFFFF_FFFF);
                chk("R10 foreign write serr", {31'b0, serr_oe}, 32'd0);
                chk("R10 foreign write ctrl", {30'b0, inta_oe, rst_oe}, 32'd0);
                rdw(AW'(a), rd);
                chk("R10 foreign read", rd, 32'd0);
            end
        end
        @(negedge clk);
        chk("R10 idle rdata", rsp_rdata, 32'd0);

        // R8: power-on reset is the only thing that clears bit 1.
        wr(AW'(RA), 32'h2);
        do_por(2'b10);
        @(negedge clk);
        chk("R8 por clears bit1", {31'b0, rst_oe}, 32'd0);
        rdw(AW'(RA), rd);
        chk("R8 bit1 after por", rd, word(2'b10, 1'b0, 1'b0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule